// File: doc/BRIEF.md
# Fixed-Point Add Execution Unit with Dual-Width Flags

This block is the add/subtract-from execution unit of a 64-bit integer pipeline. It receives an already decoded operation code, two register operands, a 16-bit immediate, the architectural carry, overflow and summary-overflow flags, and two modifier bits. One modifier asks for overflow recording and the other asks for a condition field. From these it forms one 64-bit sum whose operands are picked per operation: the register, its complement, an all-ones or zero constant, or the sign-extended immediate. The carry-in is zero, one or the incoming carry.

Carry and signed overflow are derived twice from the same sum: once at the full 64-bit width and once at the low 32 bits. The summary-overflow bit is sticky. A 4-bit condition field compares the result with zero as a signed number and carries the summary-overflow bit. A flag the operation does not record leaves the unit unchanged. All results appear on a register stage one clock after the operation is presented with `in_valid`.

Top module: `aluadd`

## Requirements
- R1: Outputs are registered. `out_valid` equals `in_valid` of the previous clock. `result`, the flags and the condition outputs change only on a clock where `in_valid` was high, and otherwise hold.
- R2: Add forms (op code = sum): 0 ADD = A+B, 1 ADDC = A+B, 2 ADDE = A+B+ca_in, 3 ADDME = A+all-ones+ca_in, 4 ADDZE = A+ca_in.
- R3: Subtract-from forms: 5 SUBF = ~A+B+1, 6 SUBFC = ~A+B+1, 7 SUBFE = ~A+B+ca_in, 8 SUBFME = ~A+all-ones+ca_in, 9 SUBFZE = ~A+ca_in, 10 NEG = ~A+1.
- R4: Immediate forms use imm sign-extended to 64 bits (S): 11 ADDI = A+S, 12 ADDIS = A+(S<<16), 13 ADDIC = A+S, 14 ADDICR = A+S, 15 SUBFIC = ~A+S+1.
- R5: When `ra_zero` is 1, ADDI yields S and ADDIS yields S<<16, regardless of A. All other op codes ignore `ra_zero`.
- R6: Op codes 1,2,3,4,6,7,8,9,13,14,15 record carry. `ca` is the carry out of bit 63 and `ca32` is the carry out of bit 31 of the same sum. Op codes 0,5,10,11,12 leave `ca`/`ca32` at `ca_in`/`ca32_in`.
- R7: For register forms (op codes 0 to 10) with `oe`=1, `ov` is the signed overflow at 64 bits and `ov32` is the signed overflow at 32 bits. Otherwise `ov`/`ov32` equal `ov_in`/`ov32_in`.
- R8: `so` = `so_in` OR (64-bit overflow recorded under R7). Arithmetic never clears it.
- R9: `cr_wr` is 1 for register forms with `rc`=1 and always for op 14. The immediate forms 11,12,13,15 ignore `rc`. When `cr_wr`=1, `cr`[3]=result<0, `cr`[2]=result>0, `cr`[1]=result==0 (signed 64-bit), and `cr`[0]=the updated `so`. When `cr_wr`=0, `cr` is 0.
- R10: While `rst_n` is low, `out_valid`, `result`, every flag, `cr_wr` and `cr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code (R2 to R4) |
| opa | input | 64 | A register operand |
| opb | input | 64 | B register operand |
| imm | input | 16 | Signed immediate |
| ra_zero | input | 1 | A register field is zero |
| ca_in | input | 1 | Current 64-bit carry |
| ca32_in | input | 1 | Current 32-bit carry |
| ov_in | input | 1 | Current 64-bit overflow |
| ov32_in | input | 1 | Current 32-bit overflow |
| so_in | input | 1 | Current summary overflow |
| oe | input | 1 | Record overflow |
| rc | input | 1 | Record condition field |
| out_valid | output | 1 | Result registers loaded last clock |
| result | output | 64 | Sum |
| ca | output | 1 | Updated 64-bit carry |
| ca32 | output | 1 | Updated 32-bit carry |
| ov | output | 1 | Updated 64-bit overflow |
| ov32 | output | 1 | Updated 32-bit overflow |
| so | output | 1 | Updated summary overflow |
| cr_wr | output | 1 | Condition field is to be written |
| cr | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
Every result, flag and condition bit is due exactly one rising edge after the clock on which its operation is presented, with no variation between operations. The bench therefore drives an operation on a falling edge and queues its expected values. It compares them on the next falling edge that shows `out_valid`, so every sample lies half a period after the register loads. Idle cycles check that the registers hold, and a result that arrives with nothing queued, or a queued item left over, counts as a miscompare.

// File: rtl/aluadd_pkg.sv
package aluadd_pkg;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_ADDC   = 4'd1,
    OP_ADDE   = 4'd2,
    OP_ADDME  = 4'd3,
    OP_ADDZE  = 4'd4,
    OP_SUBF   = 4'd5,
    OP_SUBFC  = 4'd6,
    OP_SUBFE  = 4'd7,
    OP_SUBFME = 4'd8,
    OP_SUBFZE = 4'd9,
    OP_NEG    = 4'd10,
    OP_ADDI   = 4'd11,
    OP_ADDIS  = 4'd12,
    OP_ADDIC  = 4'd13,
    OP_ADDICR = 4'd14,
    OP_SUBFIC = 4'd15
  } add_op_e;

  // operand selections for the first and second addend
  typedef enum logic [1:0] {XS_A, XS_NOTA, XS_ZERO} xsel_e;
  typedef enum logic [1:0] {YS_B, YS_ONES, YS_ZERO, YS_IMM} ysel_e;
  typedef enum logic [1:0] {CS_ZERO, CS_ONE, CS_CARRY} csel_e;

  typedef struct packed {
    xsel_e xs;
    ysel_e ys;
    csel_e cs;
    logic  imm_hi;    // shift immediate left by 16
    logic  rec_ca;    // operation records carry
    logic  reg_form;  // oe/rc honoured
    logic  cr_force;  // always write condition field
  } add_ctl_t;

endpackage

// File: rtl/aluadd_decode.sv
module aluadd_decode
  import aluadd_pkg::*;
(
  input  logic [3:0] op,
  input  logic       ra_zero,
  output add_ctl_t   ctl
);
  always_comb begin
    ctl          = '0;
    ctl.xs       = XS_A;
    ctl.ys       = YS_B;
    ctl.cs       = CS_ZERO;
    ctl.reg_form = 1'b1;
    case (add_op_e'(op))
      OP_ADD:    ;
      OP_ADDC:   ctl.rec_ca = 1'b1;
      OP_ADDE:   begin ctl.cs = CS_CARRY; ctl.rec_ca = 1'b1; end
      OP_ADDME:  begin ctl.ys = YS_ONES; ctl.cs = CS_CARRY; ctl.rec_ca = 1'b1; end
      OP_ADDZE:  begin ctl.ys = YS_ZERO; ctl.cs = CS_CARRY; ctl.rec_ca = 1'b1; end
      OP_SUBF:   begin ctl.xs = XS_NOTA; ctl.cs = CS_ONE; end
      OP_SUBFC:  begin ctl.xs = XS_NOTA; ctl.cs = CS_ONE; ctl.rec_ca = 1'b1; end
      OP_SUBFE:  begin ctl.xs = XS_NOTA; ctl.cs = CS_CARRY; ctl.rec_ca = 1'b1; end
      OP_SUBFME: begin ctl.xs = XS_NOTA; ctl.ys = YS_ONES; ctl.cs = CS_CARRY; ctl.rec_ca = 1'b1; end
      OP_SUBFZE: begin ctl.xs = XS_NOTA; ctl.ys = YS_ZERO; ctl.cs = CS_CARRY; ctl.rec_ca = 1'b1; end
      OP_NEG:    begin ctl.xs = XS_NOTA; ctl.ys = YS_ZERO; ctl.cs = CS_ONE; end
      OP_ADDI, OP_ADDIS: begin
        ctl.reg_form = 1'b0;
        ctl.ys       = YS_IMM;
        ctl.imm_hi   = (add_op_e'(op) == OP_ADDIS);
        if (ra_zero) ctl.xs = XS_ZERO;
      end
      OP_ADDIC:  begin ctl.reg_form = 1'b0; ctl.ys = YS_IMM; ctl.rec_ca = 1'b1; end
      OP_ADDICR: begin ctl.reg_form = 1'b0; ctl.ys = YS_IMM; ctl.rec_ca = 1'b1; ctl.cr_force = 1'b1; end
      OP_SUBFIC: begin
        ctl.reg_form = 1'b0;
        ctl.xs = XS_NOTA; ctl.ys = YS_IMM; ctl.cs = CS_ONE; ctl.rec_ca = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/aluadd_opsel.sv
module aluadd_opsel
  import aluadd_pkg::*;
#(
  parameter int W    = 64,
  parameter int IW   = 16
) (
  input  add_ctl_t       ctl,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  input  logic [IW-1:0]  imm,
  input  logic           ca_in,
  output logic [W-1:0]   x,
  output logic [W-1:0]   y,
  output logic           cin
);
  localparam int EXT = W - IW;
  logic [W-1:0] simm;

  always_comb begin
    simm = {{EXT{imm[IW-1]}}, imm};
    if (ctl.imm_hi) simm = simm << IW;
    case (ctl.xs)
      XS_A:    x = opa;
      XS_NOTA: x = ~opa;
      default: x = '0;
    endcase
    case (ctl.ys)
      YS_B:    y = opb;
      YS_ONES: y = '1;
      YS_IMM:  y = simm;
      default: y = '0;
    endcase
    case (ctl.cs)
      CS_ONE:   cin = 1'b1;
      CS_CARRY: cin = ca_in;
      default:  cin = 1'b0;
    endcase
  end
endmodule

// File: rtl/aluadd_core.sv
module aluadd_core #(
  parameter int W  = 64,
  parameter int HW = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic [1:0]   cout,   // [0] at HW, [1] at W
  output logic [1:0]   ovf
);
  assign sum = x + y + W'(cin);

  for (genvar g = 0; g < 2; g++) begin : g_tap
    localparam int TW = (g == 0) ? HW : W;
    logic [TW:0] part;
    always_comb begin
      part    = {1'b0, x[TW-1:0]} + {1'b0, y[TW-1:0]} + (TW+1)'(cin);
      cout[g] = part[TW];
      ovf[g]  = (x[TW-1] == y[TW-1]) && (sum[TW-1] != x[TW-1]);
    end
  end
endmodule

// File: rtl/aluadd.sv
module aluadd
  import aluadd_pkg::*;
#(
  parameter int W  = 64,
  parameter int HW = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [IW-1:0] imm,
  input  logic          ra_zero,
  input  logic          ca_in,
  input  logic          ca32_in,
  input  logic          ov_in,
  input  logic          ov32_in,
  input  logic          so_in,
  input  logic          oe,
  input  logic          rc,
  output logic          out_valid,
  output logic [W-1:0]  result,
  output logic          ca,
  output logic          ca32,
  output logic          ov,
  output logic          ov32,
  output logic          so,
  output logic          cr_wr,
  output logic [3:0]    cr
);
  add_ctl_t     ctl;
  logic [W-1:0] x, y, sum;
  logic         cin;
  logic [1:0]   cout, ovf;

  aluadd_decode u_dec (.op(op), .ra_zero(ra_zero), .ctl(ctl));

  aluadd_opsel #(.W(W), .IW(IW)) u_sel (
    .ctl(ctl), .opa(opa), .opb(opb), .imm(imm), .ca_in(ca_in),
    .x(x), .y(y), .cin(cin)
  );

  aluadd_core #(.W(W), .HW(HW)) u_core (
    .x(x), .y(y), .cin(cin), .sum(sum), .cout(cout), .ovf(ovf)
  );

  // next-state
  logic       rec_ov, ca_d, ca32_d, ov_d, ov32_d, so_d, crw_d;
  logic [3:0] cr_d;

  always_comb begin
    rec_ov = ctl.reg_form & oe;
    ca_d   = ctl.rec_ca ? cout[1] : ca_in;
    ca32_d = ctl.rec_ca ? cout[0] : ca32_in;
    ov_d   = rec_ov ? ovf[1] : ov_in;
    ov32_d = rec_ov ? ovf[0] : ov32_in;
    so_d   = so_in | (rec_ov & ovf[1]);
    crw_d  = (ctl.reg_form & rc) | ctl.cr_force;
    cr_d   = '0;
    if (crw_d) begin
      cr_d[3] = sum[W-1];
      cr_d[1] = (sum == '0);
      cr_d[2] = ~sum[W-1] & ~cr_d[1];
      cr_d[0] = so_d;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      ca        <= 1'b0;
      ca32      <= 1'b0;
      ov        <= 1'b0;
      ov32      <= 1'b0;
      so        <= 1'b0;
      cr_wr     <= 1'b0;
      cr        <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= sum;
        ca     <= ca_d;
        ca32   <= ca32_d;
        ov     <= ov_d;
        ov32   <= ov32_d;
        so     <= so_d;
        cr_wr  <= crw_d;
        cr     <= cr_d;
      end
    end
  end
endmodule

// File: rtl/aluadd_chk.sv
module aluadd_chk #(
  parameter int W  = 64,
  parameter int HW = 32,
  parameter int IW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [3:0]    op,
  input logic [W-1:0]  opa,
  input logic [W-1:0]  opb,
  input logic [IW-1:0] imm,
  input logic          ra_zero,
  input logic          ca_in,
  input logic          ca32_in,
  input logic          ov_in,
  input logic          ov32_in,
  input logic          so_in,
  input logic          oe,
  input logic          rc,
  input logic          out_valid,
  input logic [W-1:0]  result,
  input logic          ca,
  input logic          ca32,
  input logic          ov,
  input logic          ov32,
  input logic          so,
  input logic          cr_wr,
  input logic [3:0]    cr
);
  localparam int EXT = W - IW;

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(cr)));
  assert_li_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd11 && ra_zero) |=> result == $past({{EXT{imm[IW-1]}}, imm}));
  assert_carry_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd0) |=> (ca == $past(ca_in) && ca32 == $past(ca32_in)));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !oe) |=> (ov == $past(ov_in) && ov32 == $past(ov32_in)));
  assert_so_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && so_in) |=> so);
  assert_cr_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cr_wr) |-> ($countones(cr[3:1]) == 1 && cr[0] == so));
  assert_cr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 4'd11 || op == 4'd12 || op == 4'd13 || op == 4'd15)) |=> !cr_wr);
endmodule

bind aluadd aluadd_chk #(.W(W), .HW(HW), .IW(IW)) u_chk (.*);

// File: tb/aluadd_test.sv
module aluadd_test;
  localparam int W = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          in_valid = 1'b0;
  logic [3:0]    op = '0;
  logic [W-1:0]  opa = '0, opb = '0;
  logic [15:0]   imm = '0;
  logic          ra_zero = 1'b0, ca_in = 1'b0, ca32_in = 1'b0;
  logic          ov_in = 1'b0, ov32_in = 1'b0, so_in = 1'b0, oe = 1'b0, rc = 1'b0;
  logic          out_valid, ca, ca32, ov, ov32, so, cr_wr;
  logic [W-1:0]  result;
  logic [3:0]    cr;

  aluadd uut (.*);

  typedef struct {
    logic [W-1:0] res;
    logic [7:0]   fl;   // {ca,ca32,ov,ov32,so,cr_wr,2'b0}
    logic [3:0]   cr;
    string        tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  logic [W-1:0] last_res = '0;
  bit done = 0;

  function automatic exp_t model(input logic [3:0] o, input logic [W-1:0] a, b,
                                 input logic [15:0] i, input logic rz, c0, c32,
                                 input logic v0, v32, s0, e, r, input string t);
    exp_t ex;
    logic [W-1:0] xa, yb, sx;
    logic c, rca, regf;
    logic [W:0] s;
    logic [32:0] s32;
    logic signed [W+1:0] ss;
    logic signed [33:0] ss32;
    logic o64, o32, so_n, cw;
    sx = {{48{i[15]}}, i};
    rca = 1; regf = (o <= 4'd10);
    case (o)
      4'd0:  begin xa = a;  yb = b;  c = 0;  rca = 0; end
      4'd1:  begin xa = a;  yb = b;  c = 0;  end
      4'd2:  begin xa = a;  yb = b;  c = c0; end
      4'd3:  begin xa = a;  yb = '1; c = c0; end
      4'd4:  begin xa = a;  yb = 0;  c = c0; end
      4'd5:  begin xa = ~a; yb = b;  c = 1;  rca = 0; end
      4'd6:  begin xa = ~a; yb = b;  c = 1;  end
      4'd7:  begin xa = ~a; yb = b;  c = c0; end
      4'd8:  begin xa = ~a; yb = '1; c = c0; end
      4'd9:  begin xa = ~a; yb = 0;  c = c0; end
      4'd10: begin xa = ~a; yb = 0;  c = 1;  rca = 0; end
      4'd11: begin xa = rz ? 0 : a; yb = sx; c = 0; rca = 0; end
      4'd12: begin xa = rz ? 0 : a; yb = sx << 16; c = 0; rca = 0; end
      4'd15: begin xa = ~a; yb = sx; c = 1; end
      default: begin xa = a; yb = sx; c = 0; end
    endcase
    s    = {1'b0, xa} + {1'b0, yb} + (W+1)'(c);
    s32  = {1'b0, xa[31:0]} + {1'b0, yb[31:0]} + 33'(c);
    ss   = $signed({{2{xa[W-1]}}, xa}) + $signed({{2{yb[W-1]}}, yb}) + $signed((W+2)'(c));
    ss32 = $signed({{2{xa[31]}}, xa[31:0]}) + $signed({{2{yb[31]}}, yb[31:0]}) + $signed(34'(c));
    o64  = (ss[W] != ss[W-1]);
    o32  = (ss32[32] != ss32[31]);
    so_n = s0 | (regf & e & o64);
    cw   = (regf & r) | (o == 4'd14);
    ex.res = s[W-1:0];
    ex.fl  = {rca ? s[W] : c0, rca ? s32[32] : c32,
              (regf & e) ? o64 : v0, (regf & e) ? o32 : v32, so_n, cw, 2'b0};
    ex.cr  = cw ? {$signed(s[W-1:0]) < 0, $signed(s[W-1:0]) > 0, s[W-1:0] == 0, so_n} : 4'b0;
    ex.tag = t;
    return ex;
  endfunction

  task automatic send(input logic [3:0] o, input logic [W-1:0] a, b, input logic [15:0] i,
                      input logic rz, c0, c32, v0, v32, s0, e, r, input string t);
    @(negedge clk);
    in_valid = 1; op = o; opa = a; opb = b; imm = i; ra_zero = rz;
    ca_in = c0; ca32_in = c32; ov_in = v0; ov32_in = v32; so_in = s0; oe = e; rc = r;
    q.push_back(model(o, a, b, i, rz, c0, c32, v0, v32, s0, e, r, t));
  endtask

  // monitor: outputs are due one edge after the drive, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t ex;
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected result act=%h exp=none", result);
      end else begin
        ex = q.pop_front();
        if (result !== ex.res || {ca,ca32,ov,ov32,so,cr_wr,2'b0} !== ex.fl || cr !== ex.cr) begin
          fails++;
          $display("FAIL %s act=%h fl=%b cr=%b exp=%h fl=%b cr=%b", ex.tag, result,
                   {ca,ca32,ov,ov32,so,cr_wr,2'b0}, cr, ex.res, ex.fl, ex.cr);
        end
        last_res = ex.res;
      end
    end
  end

  initial begin
    #40000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  localparam logic [W-1:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [W-1:0] ONES = '1;

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R10 reset state
    if (out_valid !== 0 || result !== 0 || {ca,ca32,ov,ov32,so,cr_wr} !== 0 || cr !== 0) begin
      fails++;
      $display("FAIL R10 act=%h/%b exp=0", result, {ca,ca32,ov,ov32,so,cr_wr,cr});
    end
    rst_n = 1;
    // op, a, b, imm, raz, ca, ca32, ov, ov32, so, oe, rc
    send(4'd0,  64'd5, 64'd7, 0, 0, 1, 1, 1, 1, 0, 0, 0, "R2 add keeps flags R6");
    send(4'd1,  ONES, 64'd1, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R2 addc wrap R6 R9");
    send(4'd1,  64'h0000_0000_FFFF_FFFF, 64'd1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 ca32 only");
    send(4'd2,  64'd10, 64'd20, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R2 adde");
    send(4'd3,  64'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R2 addme ca0 R9 neg");
    send(4'd3,  64'd9, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R2 addme ca1");
    send(4'd4,  ONES, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R2 addze");
    send(4'd0,  MAXP, 64'd1, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R7 ov64 R8 R9");
    send(4'd0,  64'h0000_0000_7FFF_FFFF, 64'd1, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R7 ov32 only");
    send(4'd0,  MAXP, 64'd1, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R7 oe off R8 keeps so");
    send(4'd0,  64'd1, 64'd1, 0, 0, 0, 0, 1, 1, 1, 1, 1, "R8 sticky no ov");
    send(4'd5,  64'd3, 64'd10, 0, 0, 1, 1, 0, 0, 0, 0, 1, "R3 subf");
    send(4'd6,  64'd10, 64'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 subfc borrow");
    send(4'd7,  64'd4, 64'd4, 0, 0, 1, 0, 0, 0, 0, 0, 1, "R3 subfe zero");
    send(4'd8,  64'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 subfme");
    send(4'd9,  64'd0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R3 subfze");
    send(4'd10, 64'h8000_0000_0000_0000, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R3 neg min R7");
    send(4'd11, 64'd100, 0, 16'hFFFF, 0, 0, 0, 0, 0, 0, 1, 1, "R4 addi neg R9 ignore");
    send(4'd11, 64'd100, 0, 16'h0123, 1, 0, 0, 0, 0, 0, 0, 0, "R5 li");
    send(4'd12, 64'd100, 0, 16'h8001, 1, 0, 0, 0, 0, 0, 0, 0, "R5 lis");
    send(4'd12, 64'd1, 0, 16'h0002, 0, 0, 0, 0, 0, 0, 0, 0, "R4 addis");
    send(4'd0,  64'd6, 64'd1, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R5 ignored by add");
    send(4'd13, 64'd0, 0, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0, 1, "R4 addic R6");
    send(4'd13, 64'd1, 0, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0, 0, "R4 addic carry R6");
    send(4'd14, 64'd5, 0, 16'hFFFB, 0, 0, 0, 0, 0, 1, 0, 0, "R4 addicr R9");
    send(4'd15, 64'd7, 0, 16'd7, 0, 0, 0, 0, 0, 0, 0, 1, "R4 subfic R6");
    send(4'd15, 64'd8, 0, 16'd7, 0, 1, 1, 0, 0, 0, 0, 0, "R4 subfic borrow");
    @(negedge clk);
    in_valid = 0;
    repeat (3) @(negedge clk);
    checks++;  // R1 hold while idle
    if (out_valid !== 0 || result !== last_res || q.size() != 0) begin
      fails++;
      $display("FAIL R1 idle act=%h/%0d exp=%h/0", result, q.size(), last_res);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule